// File: doc/BRIEF.md
# XGMII Multi-Speed Word Replicator

This block sits between a 32-bit XGMII MAC port and a line datapath that always runs at the 10 Gb/s word rate. Both sides are clocked by the same 312.5 MHz word clock at every speed. Lower speeds are carried by sending each MAC word several times in a row. On transmit, the block accepts one MAC word per replication period and puts it on the line for the whole period. On receive, it takes the first valid line word of each group of the same length and passes it to the MAC with a valid strobe.

The replication factor is 1000 at 10M, 100 at 100M, 10 at 1G, 4 at 2.5G, 2 at 5G and 1 at 10G. It is chosen by a 3-bit speed code. That code comes either from a programmed field or from the result of auto-negotiation, as selected by an enable input. On receive, the spacing of valid line words is not fixed: it can shift when a packet starts or when rate matching inserts or drops words. For this reason a start-of-packet control character restarts the grouping.

Top module: `xgmii_rate_rep`

## Requirements
- R1: The speed code selects the replication factor N: 0 gives 1000, 1 gives 100, 2 gives 10, 3 gives 1, 4 gives 4 and 5 gives 2.
- R2: Speed codes 6 and 7 use N = 1.
- R3: When `an_en` is 1 the code on `an_speed` is used, and `cfg_speed` is ignored. When `an_en` is 0 the code on `cfg_speed` is used, and `an_speed` is ignored.
- R4: `tx_mac_ready` is high in the first cycle after reset and then exactly once every N cycles. It is high in every cycle when N = 1.
- R5: A word accepted (ready and valid both high) appears on `tx_line_data`/`tx_line_ctrl` for exactly N consecutive cycles, starting in the cycle after acceptance. Bytes and their control bits keep their lane: control bit i qualifies data bits 8i+7:8i, and lane 0 is the lowest byte.
- R6: When `tx_mac_valid` is low in a ready cycle, the line carries the idle word for that period: every control bit is 1 and every data byte is 0x07. The line also carries idle during reset and until the first load.
- R7: Only cycles with `rx_line_valid` high are counted. The first valid line word of each group of N valid words is presented on `rx_mac_data`/`rx_mac_ctrl` one cycle later, with `rx_mac_valid` high for one cycle. `rx_mac_valid` is low in all other cycles.
- R8: A valid line word with control bit 0 set and byte 0 equal to 0xFB (start) is always emitted and becomes the first word of a new group, whatever the group position was.
- R9: `rx_mac_valid` is low during reset and in the first cycle after it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Word clock for both directions |
| rst_n | input | 1 | Active-low synchronous reset |
| an_en | input | 1 | 1: use negotiated speed, 0: use programmed speed |
| cfg_speed | input | 3 | Programmed speed code |
| an_speed | input | 3 | Speed code resolved by auto-negotiation |
| tx_mac_data | input | 32 | Transmit word from the MAC |
| tx_mac_ctrl | input | 4 | Per-byte control flags of the transmit word |
| tx_mac_valid | input | 1 | Transmit word valid |
| tx_mac_ready | output | 1 | Block takes a transmit word this cycle |
| tx_line_data | output | 32 | Replicated transmit word toward the line |
| tx_line_ctrl | output | 4 | Control flags of the line transmit word |
| rx_line_data | input | 32 | Receive word from the line |
| rx_line_ctrl | input | 4 | Control flags of the line receive word |
| rx_line_valid | input | 1 | Receive line word valid |
| rx_mac_data | output | 32 | Decimated receive word to the MAC |
| rx_mac_ctrl | output | 4 | Control flags of the receive word to the MAC |
| rx_mac_valid | output | 1 | Receive word valid strobe |

## Verification
The hardest case to reach from the ports is a start character that lands in the middle of a receive group at the 10M factor. Such a group spans a thousand valid words, and the irregular valid pattern must shift the group phase while the group is partly filled. The stimulus holds each speed for several full periods. It drops receive valid in about one cycle in four, and it injects start characters at random positions. A behavioural model counts valid words and compares every emission cycle by cycle. The negotiated-speed path is driven with a programmed code that differs from the negotiated one, so a wrong selection changes the observed ready period.

// File: rtl/xrr_pkg.sv
package xrr_pkg;
   typedef enum logic [2:0] {
      SPD_10M  = 3'd0,
      SPD_100M = 3'd1,
      SPD_1G   = 3'd2,
      SPD_10G  = 3'd3,
      SPD_2G5  = 3'd4,
      SPD_5G   = 3'd5
   } xrr_speed_e;

   localparam logic [7:0] XRR_IDLE_BYTE  = 8'h07;
   localparam logic [7:0] XRR_START_BYTE = 8'hFB;
endpackage

// File: rtl/xrr_speed_sel.sv
module xrr_speed_sel
   import xrr_pkg::*;
#(
   parameter int F10M  = 1000,
   parameter int F100M = 100,
   parameter int F1G   = 10,
   parameter int F2G5  = 4,
   parameter int F5G   = 2,
   parameter int F10G  = 1,
   parameter int CNT_W = 10
) (
   input  logic             an_en,
   input  logic [2:0]       cfg_speed,
   input  logic [2:0]       an_speed,
   output logic [CNT_W-1:0] last_idx
);
   localparam logic [CNT_W-1:0] L10M  = CNT_W'(F10M - 1);
   localparam logic [CNT_W-1:0] L100M = CNT_W'(F100M - 1);
   localparam logic [CNT_W-1:0] L1G   = CNT_W'(F1G - 1);
   localparam logic [CNT_W-1:0] L2G5  = CNT_W'(F2G5 - 1);
   localparam logic [CNT_W-1:0] L5G   = CNT_W'(F5G - 1);
   localparam logic [CNT_W-1:0] L10G  = CNT_W'(F10G - 1);

   logic [2:0] code;

   assign code = an_en ? an_speed : cfg_speed;

   always_comb begin
      case (code)
         SPD_10M:  last_idx = L10M;
         SPD_100M: last_idx = L100M;
         SPD_1G:   last_idx = L1G;
         SPD_2G5:  last_idx = L2G5;
         SPD_5G:   last_idx = L5G;
         SPD_10G:  last_idx = L10G;
         default:  last_idx = L10G;
      endcase
   end
endmodule

// File: rtl/xrr_tx_rep.sv
module xrr_tx_rep
   import xrr_pkg::*;
#(
   parameter int LANES = 4,
   parameter int CNT_W = 10
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic [CNT_W-1:0]     last_idx,
   input  logic [8*LANES-1:0]   mac_data,
   input  logic [LANES-1:0]     mac_ctrl,
   input  logic                 mac_valid,
   output logic                 mac_ready,
   output logic [8*LANES-1:0]   line_data,
   output logic [LANES-1:0]     line_ctrl
);
   localparam int DATA_W = 8 * LANES;
   localparam logic [DATA_W-1:0] IDLE_D = {LANES{XRR_IDLE_BYTE}};
   localparam logic [LANES-1:0]  IDLE_C = {LANES{1'b1}};

   logic [CNT_W-1:0] phase;
   logic             at_start;

   assign at_start  = (phase == '0);
   assign mac_ready = at_start;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         phase     <= '0;
         line_data <= IDLE_D;
         line_ctrl <= IDLE_C;
      end else begin
         phase <= (phase >= last_idx) ? '0 : phase + CNT_W'(1);
         if (at_start) begin
            line_data <= mac_valid ? mac_data : IDLE_D;
            line_ctrl <= mac_valid ? mac_ctrl : IDLE_C;
         end
      end
   end
endmodule

// File: rtl/xrr_rx_dec.sv
module xrr_rx_dec
   import xrr_pkg::*;
#(
   parameter int LANES           = 4,
   parameter int CNT_W           = 10,
   parameter bit ALIGN_ON_START  = 1'b1
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic [CNT_W-1:0]     last_idx,
   input  logic [8*LANES-1:0]   line_data,
   input  logic [LANES-1:0]     line_ctrl,
   input  logic                 line_valid,
   output logic [8*LANES-1:0]   mac_data,
   output logic [LANES-1:0]     mac_ctrl,
   output logic                 mac_valid
);
   logic [CNT_W-1:0] slot;
   logic             is_start;
   logic             take;

   generate
      if (ALIGN_ON_START) begin : g_align
         assign is_start = line_ctrl[0] && (line_data[7:0] == XRR_START_BYTE);
      end else begin : g_free
         assign is_start = 1'b0;
      end
   endgenerate

   assign take = line_valid && ((slot == '0) || is_start);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         slot      <= '0;
         mac_valid <= 1'b0;
         mac_data  <= '0;
         mac_ctrl  <= '0;
      end else begin
         mac_valid <= take;
         if (take) begin
            mac_data <= line_data;
            mac_ctrl <= line_ctrl;
         end
         if (line_valid) begin
            if (take)
               slot <= (last_idx == '0) ? '0 : CNT_W'(1);
            else
               slot <= (slot >= last_idx) ? '0 : slot + CNT_W'(1);
         end
      end
   end
endmodule

// File: rtl/xgmii_rate_rep.sv
module xgmii_rate_rep
   import xrr_pkg::*;
#(
   parameter int LANES            = 4,
   parameter int F10M             = 1000,
   parameter int F100M            = 100,
   parameter int F1G              = 10,
   parameter int F2G5             = 4,
   parameter int F5G              = 2,
   parameter int F10G             = 1,
   parameter bit RX_ALIGN_ON_START = 1'b1
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        an_en,
   input  logic [2:0]  cfg_speed,
   input  logic [2:0]  an_speed,
   input  logic [31:0] tx_mac_data,
   input  logic [3:0]  tx_mac_ctrl,
   input  logic        tx_mac_valid,
   output logic        tx_mac_ready,
   output logic [31:0] tx_line_data,
   output logic [3:0]  tx_line_ctrl,
   input  logic [31:0] rx_line_data,
   input  logic [3:0]  rx_line_ctrl,
   input  logic        rx_line_valid,
   output logic [31:0] rx_mac_data,
   output logic [3:0]  rx_mac_ctrl,
   output logic        rx_mac_valid
);
   localparam int DATA_W = 8 * LANES;
   localparam int MAXF   = F10M;
   localparam int CNT_W  = $clog2(MAXF + 1);

   generate
      if (DATA_W != 32) begin : g_bad_width
         $error("xgmii_rate_rep: port width fixed at 32 bits, LANES must be 4");
      end
      if (!(F10G >= 1 && F5G >= F10G && F2G5 >= F5G && F1G >= F2G5 &&
            F100M >= F1G && F10M >= F100M)) begin : g_bad_factor
         $error("xgmii_rate_rep: factors must be >= 1 and fall with speed");
      end
   endgenerate

   logic [CNT_W-1:0] last_idx;

   xrr_speed_sel #(
      .F10M (F10M), .F100M(F100M), .F1G(F1G),
      .F2G5 (F2G5), .F5G  (F5G),   .F10G(F10G),
      .CNT_W(CNT_W)
   ) u_sel (
      .an_en    (an_en),
      .cfg_speed(cfg_speed),
      .an_speed (an_speed),
      .last_idx (last_idx)
   );

   xrr_tx_rep #(.LANES(LANES), .CNT_W(CNT_W)) u_tx (
      .clk      (clk),
      .rst_n    (rst_n),
      .last_idx (last_idx),
      .mac_data (tx_mac_data),
      .mac_ctrl (tx_mac_ctrl),
      .mac_valid(tx_mac_valid),
      .mac_ready(tx_mac_ready),
      .line_data(tx_line_data),
      .line_ctrl(tx_line_ctrl)
   );

   xrr_rx_dec #(
      .LANES(LANES), .CNT_W(CNT_W), .ALIGN_ON_START(RX_ALIGN_ON_START)
   ) u_rx (
      .clk       (clk),
      .rst_n     (rst_n),
      .last_idx  (last_idx),
      .line_data (rx_line_data),
      .line_ctrl (rx_line_ctrl),
      .line_valid(rx_line_valid),
      .mac_data  (rx_mac_data),
      .mac_ctrl  (rx_mac_ctrl),
      .mac_valid (rx_mac_valid)
   );
endmodule

// File: rtl/xrr_chk.sv
module xrr_chk #(
   parameter int CNT_W = 10
) (
   input logic             clk,
   input logic             rst_n,
   input logic [CNT_W-1:0] last_idx,
   input logic             tx_mac_valid,
   input logic             tx_mac_ready,
   input logic [31:0]      tx_line_data,
   input logic [3:0]       tx_line_ctrl,
   input logic [31:0]      rx_line_data,
   input logic [3:0]       rx_line_ctrl,
   input logic             rx_line_valid,
   input logic [31:0]      rx_mac_data,
   input logic             rx_mac_valid
);
   // R4
   single_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (tx_mac_ready && last_idx != '0) |=> !tx_mac_ready);

   // R5
   line_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !tx_mac_ready |=> ($stable(tx_line_data) && $stable(tx_line_ctrl)));

   // R6
   idle_fill_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (tx_mac_ready && !tx_mac_valid) |=>
         (tx_line_ctrl == 4'hF && tx_line_data == 32'h0707_0707));

   // R7
   rx_needs_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rx_mac_valid |-> $past(rx_line_valid));

   // R8
   start_emit_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rx_line_valid && rx_line_ctrl[0] && rx_line_data[7:0] == 8'hFB) |=>
         (rx_mac_valid && rx_mac_data == $past(rx_line_data)));
endmodule

bind xgmii_rate_rep xrr_chk #(.CNT_W(CNT_W)) u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .last_idx     (last_idx),
   .tx_mac_valid (tx_mac_valid),
   .tx_mac_ready (tx_mac_ready),
   .tx_line_data (tx_line_data),
   .tx_line_ctrl (tx_line_ctrl),
   .rx_line_data (rx_line_data),
   .rx_line_ctrl (rx_line_ctrl),
   .rx_line_valid(rx_line_valid),
   .rx_mac_data  (rx_mac_data),
   .rx_mac_valid (rx_mac_valid)
);

// File: tb/xgmii_rate_rep_test.sv
module xgmii_rate_rep_test;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        an_en = 1'b0;
   logic [2:0]  cfg_speed = 3'd0;
   logic [2:0]  an_speed = 3'd0;
   logic [31:0] tx_mac_data = '0;
   logic [3:0]  tx_mac_ctrl = '0;
   logic        tx_mac_valid = 1'b0;
   logic        tx_mac_ready;
   logic [31:0] tx_line_data;
   logic [3:0]  tx_line_ctrl;
   logic [31:0] rx_line_data = '0;
   logic [3:0]  rx_line_ctrl = '0;
   logic        rx_line_valid = 1'b0;
   logic [31:0] rx_mac_data;
   logic [3:0]  rx_mac_ctrl;
   logic        rx_mac_valid;

   int  vectors = 0;
   int  miscompares = 0;
   bit  done = 1'b0;

   always #10 clk = ~clk;

   xgmii_rate_rep uut (
      .clk(clk), .rst_n(rst_n), .an_en(an_en),
      .cfg_speed(cfg_speed), .an_speed(an_speed),
      .tx_mac_data(tx_mac_data), .tx_mac_ctrl(tx_mac_ctrl),
      .tx_mac_valid(tx_mac_valid), .tx_mac_ready(tx_mac_ready),
      .tx_line_data(tx_line_data), .tx_line_ctrl(tx_line_ctrl),
      .rx_line_data(rx_line_data), .rx_line_ctrl(rx_line_ctrl),
      .rx_line_valid(rx_line_valid), .rx_mac_data(rx_mac_data),
      .rx_mac_ctrl(rx_mac_ctrl), .rx_mac_valid(rx_mac_valid)
   );

   localparam logic [35:0] IDLE_W = {4'hF, 32'h0707_0707};

   task automatic check(input bit ok, input string req, input string what,
                        input logic [63:0] act, input logic [63:0] exp);
      vectors++;
      if (!ok) begin
         miscompares++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
      end
   endtask

   task automatic run_cfg(input bit ae, input logic [2:0] cs, input logic [2:0] as,
                          input int nfac, input string tag);
      logic [35:0] q[$];
      int          rc = 0;
      bit          pend_v = 1'b0;
      bit          pend_st = 1'b0;
      logic [35:0] pend_w = '0;
      int          ncyc = 4 * nfac + 40;
      @(negedge clk);
      rst_n = 1'b0; an_en = ae; cfg_speed = cs; an_speed = as;
      tx_mac_valid = 1'b0; rx_line_valid = 1'b0;
      repeat (3) @(negedge clk);
      // R6 R9: state during reset
      check({tx_line_ctrl, tx_line_data} == IDLE_W, "R6", "idle in reset",
            {28'd0, tx_line_ctrl, tx_line_data}, {28'd0, IDLE_W});
      check(rx_mac_valid == 1'b0, "R9", "rx valid in reset", 64'(rx_mac_valid), 64'd0);
      rst_n = 1'b1;
      for (int j = 0; j < ncyc; j++) begin
         logic [31:0] d;
         logic [3:0]  c;
         bit          v;
         bit          st;
         bit          emit;
         if (j > 0) begin
            logic [35:0] e = q.pop_front();
            check({tx_line_ctrl, tx_line_data} == e, (e == IDLE_W) ? "R6" : "R5",
                  "tx line word", {28'd0, tx_line_ctrl, tx_line_data}, {28'd0, e});
            check(rx_mac_valid == pend_v, (j == 1) ? "R9" : (pend_st ? "R8" : "R7"),
                  "rx valid", 64'(rx_mac_valid), 64'(pend_v));
            if (pend_v)
               check({rx_mac_ctrl, rx_mac_data} == pend_w, pend_st ? "R8" : "R7",
                     "rx word", {28'd0, rx_mac_ctrl, rx_mac_data}, {28'd0, pend_w});
         end
         // R4 plus speed selection tag (R1/R2/R3)
         check(tx_mac_ready == ((j % nfac) == 0), (j < nfac) ? "R4" : tag,
               "ready period", 64'(tx_mac_ready), 64'((j % nfac) == 0));
         tx_mac_data  = $urandom;
         tx_mac_ctrl  = 4'($urandom);
         tx_mac_valid = ($urandom_range(3, 0) != 0);
         if ((j % nfac) == 0)
            for (int k = 0; k < nfac; k++)
               q.push_back(tx_mac_valid ? {tx_mac_ctrl, tx_mac_data} : IDLE_W);
         d = $urandom;
         c = 4'($urandom);
         v = ($urandom_range(3, 0) != 0);
         if ($urandom_range(15, 0) == 0) begin
            d[7:0] = 8'hFB;
            c[0]   = 1'b1;
         end
         rx_line_data = d; rx_line_ctrl = c; rx_line_valid = v;
         st   = v && c[0] && (d[7:0] == 8'hFB);
         emit = v && (rc == 0 || st);
         if (v) rc = emit ? (1 % nfac) : ((rc + 1) % nfac);
         pend_v = emit; pend_st = st; pend_w = {c, d};
         @(negedge clk);
      end
   endtask

   initial begin
      run_cfg(1'b0, 3'd0, 3'd3, 1000, "R1");
      run_cfg(1'b0, 3'd1, 3'd3, 100, "R1");
      run_cfg(1'b0, 3'd2, 3'd0, 10, "R1");
      run_cfg(1'b0, 3'd3, 3'd0, 1, "R1");
      run_cfg(1'b0, 3'd4, 3'd2, 4, "R1");
      run_cfg(1'b0, 3'd5, 3'd1, 2, "R1");
      run_cfg(1'b0, 3'd6, 3'd2, 1, "R2");
      run_cfg(1'b0, 3'd7, 3'd2, 1, "R2");
      run_cfg(1'b1, 3'd3, 3'd2, 10, "R3");
      run_cfg(1'b1, 3'd2, 3'd5, 2, "R3");
      run_cfg(1'b1, 3'd0, 3'd7, 1, "R3");
      if (!done) begin
         done = 1'b1;
         $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
         $finish;
      end
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         done = 1'b1;
         vectors++;
         miscompares++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
         $finish;
      end
   end
endmodule